// File: doc/BRIEF.md
# SD card clock generator

This block derives the card bus clock of an SD/MMC host controller from a faster
peripheral clock. Software programs a rate word and issues start, stop and soft
reset commands. The block divides the input clock in two cascaded stages. A
small divider stage divides by its field value plus one. A prescaler stage then
divides by twice its field value, and a prescaler value of zero removes that
stage from the path entirely.

The block drives the card clock itself and a one-cycle enable strobe that the
command and data logic use to step in time with the card clock. It also drives a
running flag for the status register and a readback copy of the rate word.
Commands and rate changes only take effect at points where the card clock is
low, so the card never sees a shortened pulse. Stopping the clock lets the
current period run to its end. A rate change made while the clock runs is
applied at the next period boundary. A soft reset stops the clock and clears
the counters at once, but keeps the programmed rate.

Top module: `sd_clkgen`

## Requirements
- R1: After reset, card_clk, clk_en and running are 0 and rate_q is 0.
- R2: The rate word holds the divider in rate_wdata[3:0] and the prescaler in rate_wdata[15:4]. A write updates rate_q on the next clock edge and is read back unchanged.
- R3: With prescaler 0 and divider N (1 to 15), the card clock period is N+1 input cycles, and the clock is high for the first floor((N+1)/2) of those cycles.
- R4: With a nonzero prescaler P and divider N, the period is (N+1)*2*P input cycles, and the clock is high for the first (N+1)*P of them. For example, N=15 and P=4 give 128 cycles.
- R5: A divider field of 0 acts as a divider of 1.
- R6: A command write with bit 1 (start) set while stopped sets running on the next edge. The card clock rises one edge after that.
- R7: A command write with bit 0 (stop) set while running lets the current period finish. running clears at the end of that period, and card_clk then stays low.
- R8: A rate write while running leaves the current period at the old rate. The new rate applies from the next period boundary.
- R9: A command write with bit 2 (soft reset) set forces card_clk and running low on the next edge and leaves rate_q unchanged. A later start begins a fresh full period.
- R10: clk_en pulses for exactly one input cycle per card clock period, namely the first cycle of the high phase.
- R11: Start takes priority over stop. A start cancels a pending stop, and a write with both bits set keeps the clock running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral input clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_we | input | 1 | Rate word write strobe |
| rate_wdata | input | 16 | Rate word: divider [3:0], prescaler [15:4] |
| cmd_we | input | 1 | Command write strobe |
| cmd_wdata | input | 3 | Command: bit 0 stop, bit 1 start, bit 2 soft reset |
| card_clk | output | 1 | Card bus clock |
| clk_en | output | 1 | One-cycle strobe at each card clock rising phase |
| running | output | 1 | Card clock is running |
| rate_q | output | 16 | Programmed rate word readback |

## Verification
Assertions check the following on every cycle:
- The card clock is low whenever the generator is stopped.
- The enable strobe coincides with each rise of the card clock and never appears while the clock is low.
- The division counters never pass their terminal counts.
- The active rate holds steady between period boundaries.
- A start or soft reset moves the running flag on the next edge.
- Running can only drop at a period boundary or on a soft reset.

Only the bench scenarios can show the measured period and high time for each divider and prescaler combination. They also show the exact cycle at which a mid-period rate change takes effect, and the way start overrides stop.

// File: rtl/sd_clkgen_pkg.sv
package sd_clkgen_pkg;
  // Command word bit positions
  localparam int CMD_W        = 3;
  localparam int CMD_STOP_BIT = 0;
  localparam int CMD_GO_BIT   = 1;
  localparam int CMD_SRST_BIT = 2;
endpackage

// File: rtl/sd_clkgen_count.sv
module sd_clkgen_count #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] term,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  localparam logic [W-1:0] ONE = W'(1);

  assign wrap = (cnt == term);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (en)    cnt <= wrap ? '0 : cnt + ONE;
  end

  // R3/R4: a stage counter never runs past its terminal count
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
    cnt <= term);
endmodule

// File: rtl/sd_clkgen_rate.sv
module sd_clkgen_rate #(
  parameter int DIV_W = 4,
  parameter int PRE_W = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [DIV_W+PRE_W-1:0] wr_data,
  input  logic                   load,
  output logic [DIV_W+PRE_W-1:0] rate_q,
  output logic [DIV_W-1:0]       div_eff,
  output logic [PRE_W-1:0]       pre_act
);
  logic [DIV_W-1:0] div_act;

  always_ff @(posedge clk) begin
    if (rst)        rate_q <= '0;
    else if (wr_en) rate_q <= wr_data;
  end

  // Working copy, only refreshed while stopped or at a period boundary
  always_ff @(posedge clk) begin
    if (rst) begin
      div_act <= '0;
      pre_act <= '0;
    end else if (load) begin
      div_act <= rate_q[DIV_W-1:0];
      pre_act <= rate_q[DIV_W+PRE_W-1:DIV_W];
    end
  end

  // R5: a zero divider behaves as one
  assign div_eff = (div_act == '0) ? DIV_W'(1) : div_act;

  // R8: active rate is frozen between boundaries
  p_rate_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(div_act) && $stable(pre_act)));
endmodule

// File: rtl/sd_clkgen_run.sv
module sd_clkgen_run
  import sd_clkgen_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_we,
  input  logic [CMD_W-1:0] cmd,
  input  logic             period_end,
  output logic             running,
  output logic             soft_rst
);
  logic stop_pend;
  logic go_cmd;
  logic halt_cmd;

  assign soft_rst = cmd_we && cmd[CMD_SRST_BIT];
  assign go_cmd   = cmd_we && cmd[CMD_GO_BIT] && !soft_rst;
  assign halt_cmd = cmd_we && cmd[CMD_STOP_BIT] && !cmd[CMD_GO_BIT] && !soft_rst;

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      running   <= 1'b0;
      stop_pend <= 1'b0;
    end else if (go_cmd) begin
      running   <= 1'b1;
      stop_pend <= 1'b0;
    end else if (period_end && (stop_pend || halt_cmd)) begin
      running   <= 1'b0;
      stop_pend <= 1'b0;
    end else if (halt_cmd && running) begin
      stop_pend <= 1'b1;
    end
  end

  // R9: soft reset stops at once
  p_srst_stops_r9: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> !running);

  // R6/R11: start always wins and runs on the next edge
  p_start_runs_r6: assert property (@(posedge clk) disable iff (rst)
    go_cmd |=> running);

  // R7: running only drops at a period boundary or on soft reset
  p_stop_at_end_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(running) |-> ($past(period_end) || $past(soft_rst)));
endmodule

// File: rtl/sd_clkgen.sv
module sd_clkgen
  import sd_clkgen_pkg::*;
#(
  parameter int DIV_W = 4,
  parameter int PRE_W = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rate_we,
  input  logic [DIV_W+PRE_W-1:0] rate_wdata,
  input  logic                   cmd_we,
  input  logic [CMD_W-1:0]       cmd_wdata,
  output logic                   card_clk,
  output logic                   clk_en,
  output logic                   running,
  output logic [DIV_W+PRE_W-1:0] rate_q
);
  localparam int P2_W = PRE_W + 1;
  localparam logic [DIV_W:0] HALF_ONE = (DIV_W+1)'(1);
  localparam logic [P2_W-1:0] P2_ONE  = P2_W'(1);

  logic              soft_rst;
  logic              period_end;
  logic              load;
  logic [DIV_W-1:0]  div_eff;
  logic [PRE_W-1:0]  pre_act;
  logic              bypass;
  logic [DIV_W:0]    half;
  logic [P2_W-1:0]   term2;
  logic [DIV_W-1:0]  cnt1;
  logic [P2_W-1:0]   cnt2;
  logic              wrap1;
  logic              wrap2;
  logic              high_phase;
  logic              card_clk_q;
  logic              clk_en_q;

  sd_clkgen_run u_run (
    .clk        (clk),
    .rst        (rst),
    .cmd_we     (cmd_we),
    .cmd        (cmd_wdata),
    .period_end (period_end),
    .running    (running),
    .soft_rst   (soft_rst)
  );

  assign load = !running || period_end;

  sd_clkgen_rate #(.DIV_W(DIV_W), .PRE_W(PRE_W)) u_rate (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (rate_we),
    .wr_data (rate_wdata),
    .load    (load),
    .rate_q  (rate_q),
    .div_eff (div_eff),
    .pre_act (pre_act)
  );

  // Stage terms
  assign bypass = (pre_act == '0);
  assign half   = ({1'b0, div_eff} + HALF_ONE) >> 1;
  assign term2  = {pre_act, 1'b0} - P2_ONE;

  // Stage 1: divide by (divider + 1)
  sd_clkgen_count #(.W(DIV_W)) u_div (
    .clk  (clk),
    .rst  (rst),
    .clr  (soft_rst || !running),
    .en   (running),
    .term (div_eff),
    .cnt  (cnt1),
    .wrap (wrap1)
  );

  // Stage 2: divide by 2 * prescaler, held at zero when bypassed
  sd_clkgen_count #(.W(P2_W)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .clr  (soft_rst || !running || bypass),
    .en   (running && wrap1),
    .term (term2),
    .cnt  (cnt2),
    .wrap (wrap2)
  );

  assign period_end = running && wrap1 && (bypass || wrap2);
  assign high_phase = bypass ? ({1'b0, cnt1} < half)
                             : (cnt2 < {1'b0, pre_act});

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      card_clk_q <= 1'b0;
      clk_en_q   <= 1'b0;
    end else begin
      card_clk_q <= running && high_phase;
      clk_en_q   <= running && (cnt1 == '0) && (cnt2 == '0);
    end
  end

  assign card_clk = card_clk_q;
  assign clk_en   = clk_en_q;

  // R7: stopped generator holds the card clock low
  p_idle_low_r7: assert property (@(posedge clk) disable iff (rst)
    !running |=> !card_clk);

  // R10: strobe only inside the high phase
  p_en_in_high_r10: assert property (@(posedge clk) disable iff (rst)
    clk_en |-> card_clk);

  // R10: every rising card clock carries the strobe
  p_rise_strobe_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(card_clk) |-> clk_en);
endmodule

// File: tb/sd_clkgen_bench.sv
module sd_clkgen_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        rate_we;
  logic [15:0] rate_wdata;
  logic        cmd_we;
  logic [2:0]  cmd_wdata;
  logic        card_clk;
  logic        clk_en;
  logic        running;
  logic [15:0] rate_q;

  int n_checks = 0;
  int n_fails  = 0;

  localparam logic [2:0] C_STOP = 3'b001;
  localparam logic [2:0] C_GO   = 3'b010;
  localparam logic [2:0] C_SRST = 3'b100;

  always #(CLK_PERIOD/2) clk = ~clk;

  sd_clkgen u_sd_clkgen (
    .clk        (clk),
    .rst        (rst),
    .rate_we    (rate_we),
    .rate_wdata (rate_wdata),
    .cmd_we     (cmd_we),
    .cmd_wdata  (cmd_wdata),
    .card_clk   (card_clk),
    .clk_en     (clk_en),
    .running    (running),
    .rate_q     (rate_q)
  );

  task automatic check(input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr_rate(input logic [15:0] v);
    @(negedge clk);
    rate_we = 1'b1; rate_wdata = v;
    @(negedge clk);
    rate_we = 1'b0;
  endtask

  task automatic wr_cmd(input logic [2:0] v);
    @(negedge clk);
    cmd_we = 1'b1; cmd_wdata = v;
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  // Ends on a negedge where clk_en is high (start of a period)
  task automatic measure(output int per, output int hi, output int ens);
    int guard = 0;
    while (!clk_en && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    per = 0; hi = 0; ens = 0;
    do begin
      if (card_clk) hi++;
      if (clk_en) ens++;
      per++;
      @(negedge clk);
    end while (!clk_en && per < 1000);
  endtask

  task automatic run_rate(input string req, input logic [15:0] v,
                          input int exp_per, input int exp_hi);
    int per, hi, ens;
    wr_cmd(C_SRST);
    wr_rate(v);
    wr_cmd(C_GO);
    measure(per, hi, ens);
    check(req, "period", per, exp_per);
    check(req, "high time", hi, exp_hi);
    check("R10", "strobes per period", ens, 1);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "card_clk", card_clk, 0);
    check("R1", "clk_en", clk_en, 0);
    check("R1", "running", running, 0);
    check("R1", "rate_q", rate_q, 0);
  endtask

  task automatic t_fields;
    wr_rate(16'h0A45);
    check("R2", "rate_q readback", rate_q, 16'h0A45);
    // divider 5, prescaler 4: 6*8 cycles
    run_rate("R2", 16'h0045, 48, 24);
  endtask

  task automatic t_bypass;
    run_rate("R3", 16'h0003, 4, 2);
    run_rate("R3", 16'h0004, 5, 2);
    run_rate("R3", 16'h000F, 16, 8);
  endtask

  task automatic t_div_zero;
    run_rate("R5", 16'h0000, 2, 1);
  endtask

  task automatic t_prescaled;
    run_rate("R4", 16'h0011, 4, 2);
    run_rate("R4", 16'h0042, 24, 12);
    run_rate("R4", 16'h004F, 128, 64);
  endtask

  task automatic t_start;
    wr_cmd(C_SRST);
    wr_rate(16'h0003);
    wr_cmd(C_GO);
    check("R6", "running after start", running, 1);
    check("R6", "card_clk still low", card_clk, 0);
    @(negedge clk);
    check("R6", "card_clk risen", card_clk, 1);
    check("R10", "strobe at rise", clk_en, 1);
  endtask

  task automatic t_stop;
    int per, hi, ens, highs;
    wr_cmd(C_SRST);
    wr_rate(16'h0003);
    wr_cmd(C_GO);
    measure(per, hi, ens);
    wr_cmd(C_STOP);
    check("R7", "running while period ends", running, 1);
    @(negedge clk);
    check("R7", "running cleared at boundary", running, 0);
    highs = 0;
    for (int i = 0; i < 12; i++) begin
      if (card_clk || clk_en) highs++;
      @(negedge clk);
    end
    check("R7", "card_clk high cycles after stop", highs, 0);
  endtask

  task automatic t_retime;
    int per, hi, ens, wait_n;
    wr_cmd(C_SRST);
    wr_rate(16'h0003);
    wr_cmd(C_GO);
    measure(per, hi, ens);
    wr_rate(16'h0007);
    wait_n = 0;
    while (!clk_en && wait_n < 100) begin
      @(negedge clk);
      wait_n++;
    end
    check("R8", "old period finishes", wait_n, 2);
    measure(per, hi, ens);
    check("R8", "new period", per, 8);
    check("R8", "new high time", hi, 4);
  endtask

  task automatic t_soft;
    int per, hi, ens, highs;
    wr_cmd(C_SRST);
    wr_rate(16'h0007);
    wr_cmd(C_GO);
    measure(per, hi, ens);
    wr_cmd(C_SRST);
    check("R9", "card_clk low", card_clk, 0);
    check("R9", "running low", running, 0);
    check("R9", "rate kept", rate_q, 16'h0007);
    highs = 0;
    for (int i = 0; i < 6; i++) begin
      if (card_clk) highs++;
      @(negedge clk);
    end
    check("R9", "quiet after soft reset", highs, 0);
    wr_cmd(C_GO);
    @(negedge clk);
    per = 0;
    do begin
      per++;
      @(negedge clk);
    end while (!clk_en && per < 100);
    check("R9", "fresh period after restart", per, 8);
  endtask

  task automatic t_priority;
    int per, hi, ens;
    wr_cmd(C_SRST);
    wr_rate(16'h0007);
    wr_cmd(C_GO);
    measure(per, hi, ens);
    wr_cmd(C_STOP);
    wr_cmd(C_GO);
    repeat (20) @(negedge clk);
    check("R11", "start cancels pending stop", running, 1);
    wr_cmd(C_STOP | C_GO);
    repeat (20) @(negedge clk);
    check("R11", "both bits keep running", running, 1);
    measure(per, hi, ens);
    check("R11", "period unchanged", per, 8);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst = 1'b1; rate_we = 1'b0; rate_wdata = '0;
    cmd_we = 1'b0; cmd_wdata = '0;
    t_reset();
    t_fields();
    t_bypass();
    t_div_zero();
    t_prescaled();
    t_start();
    t_stop();
    t_retime();
    t_soft();
    t_priority();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule